// File: doc/BRIEF.md
# Local Interrupt Priority Controller

This block sits beside a processor core and arbitrates vectored interrupt requests by priority. Each request carries an 8-bit vector, a trigger type (edge or level) and a flag that marks it as a delivery type exempt from priority gating. Accepted requests are held in a pending bitmap. A second bitmap records which vectors the core is currently servicing. The block combines a software-written task priority with the highest in-service vector to form a processor priority. It raises the interrupt line while some pending vector outranks that threshold, or while some exempt request is waiting.

When the core acknowledges, the block answers one cycle later with the winning vector and moves that vector from pending to in-service. If nothing qualifies at that moment, for example because the task priority was raised after the line went up, the block answers with a programmable spurious vector and changes no state. Writing to the end-of-interrupt strobe retires the highest in-service vector. When that vector was level-triggered, the block also emits a one-cycle broadcast carrying its number. Any 32-bit word of the pending, in-service or trigger bitmaps can be read through a bank/word select.

Top module: `lpic_ctrl`

## Requirements
- R1: After reset, the pending, in-service and trigger bitmaps are all zero, irq_out, ack_valid and eoi_bcast are 0, ppr_out is 0, and the spurious vector register holds 0xFF with its enable bit clear.
- R2: A request with vector below 16 is ignored. A request with vector v of 16 or above sets pending bit v (bit v%32 of word v/32) and loads trigger bit v with req_level, where 1 means level-triggered.
- R3: The class of a vector is bits [7:4]. The processor-priority class is the larger of the task-priority class and the class of the highest in-service vector. ppr_out equals the task priority when its class is at least the in-service class; otherwise it equals the in-service class followed by four zero bits.
- R4: irq_out is 1 exactly when the spurious register's enable bit is set and some pending vector is eligible. A vector is eligible when its class is strictly greater than the processor-priority class, or when it was requested with req_bypass set.
- R5: On inta, the highest-numbered eligible vector wins. In the next cycle ack_valid is 1, ack_vector holds the winner and ack_spurious is 0. From that cycle on, the winner's pending bit is clear and its in-service bit is set.
- R6: If no vector is eligible at inta, ack_vector in the next cycle is the spurious vector, ack_spurious is 1, and neither bitmap changes.
- R7: A request made with req_bypass set is delivered even when the task-priority class is 15.
- R8: An eoi_we pulse clears the highest set in-service bit. When the in-service bitmap is empty, it has no effect.
- R9: When the retired vector's trigger bit is 1, eoi_bcast is 1 for one cycle, in the cycle after the eoi_we pulse, and eoi_bcast_vector holds the retired vector. An edge-triggered retirement leaves eoi_bcast at 0.
- R10: While the spurious register's enable bit (svr_wdata bit 8) is clear, irq_out stays 0 and inta returns the spurious vector with the pending bitmap left unchanged.
- R11: rd_data returns word rd_word of the bank picked by rd_bank: 0 selects pending, 1 in-service, 2 trigger. Bank 3 reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_vector | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered request |
| req_bypass | input | 1 | 1 = request ignores the priority threshold |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority value |
| svr_we | input | 1 | Spurious-register write strobe |
| svr_wdata | input | 9 | Bit 8 enable, bits 7:0 spurious vector |
| eoi_we | input | 1 | End-of-interrupt strobe |
| inta | input | 1 | Interrupt acknowledge |
| rd_bank | input | 2 | Readout bank select |
| rd_word | input | 3 | Readout word index |
| irq_out | output | 1 | Interrupt line to the core |
| ack_valid | output | 1 | Acknowledge answer valid |
| ack_vector | output | 8 | Acknowledged or spurious vector |
| ack_spurious | output | 1 | Answer is the spurious vector |
| ppr_out | output | 8 | Current processor priority |
| eoi_bcast | output | 1 | Level-triggered retirement pulse |
| eoi_bcast_vector | output | 8 | Retired level-triggered vector |
| rd_data | output | 32 | Selected bitmap word |

## Verification
The bench raises the task priority between request and acknowledge. A design that gated on the old threshold would hand out a real vector and corrupt the in-service bitmap, where a spurious answer is required. It sets the task-priority class equal to a request's class, where a design that compared with greater-or-equal would raise the line wrongly. It also sends exempt requests under a class-15 task priority, which a design that gated them would starve. Further cases cover end-of-interrupt on an empty in-service set, retirement of level-triggered against edge-triggered vectors (a wrong design would broadcast on the edge case or miss the level case), and vectors below 16, which must never become pending.

// File: rtl/lpic_pkg.sv
// Shared definitions for the local interrupt priority controller.
// Assumes an 8-bit vector space whose upper four bits form the class.
package lpic_pkg;
    localparam int CLASS_W = 4;

    typedef enum logic [1:0] {
        BANK_PEND  = 2'd0,
        BANK_ISR   = 2'd1,
        BANK_TRIG  = 2'd2,
        BANK_EMPTY = 2'd3
    } bank_e;
endpackage

// File: rtl/lpic_find_top.sv
// Finds the highest-numbered set bit of a vector.
// Assumes N is a power of two; idx is zero when nothing is set.
module lpic_find_top #(
    parameter int N  = 256,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  bits,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan upward so that the last hit, the highest index, wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (bits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/lpic_vec_store.sv
// Holds the pending, in-service, trigger and bypass bitmaps and the word readout.
// Assumes at most one take and one retirement per cycle. A set from a request
// overrides a same-cycle clear of the same pending bit, and a take overrides a
// same-cycle retirement of the same in-service bit.
module lpic_vec_store #(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    parameter int MIN_VEC = 16,
    localparam int VW     = $clog2(NUM_VEC),
    localparam int NWORDS = NUM_VEC / WORD_W,
    localparam int WSW    = $clog2(NWORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [VW-1:0]      req_vec,
    input  logic               req_level,
    input  logic               req_bypass,
    input  logic               take,
    input  logic [VW-1:0]      take_vec,
    input  logic               eoi_do,
    input  logic [VW-1:0]      eoi_vec,
    input  lpic_pkg::bank_e    rd_bank,
    input  logic [WSW-1:0]     rd_word,
    output logic [NUM_VEC-1:0] pend,
    output logic [NUM_VEC-1:0] isr,
    output logic [NUM_VEC-1:0] tmr,
    output logic [NUM_VEC-1:0] byp,
    output logic [WORD_W-1:0]  rd_data
);
    import lpic_pkg::*;

    logic                req_ok;
    logic [WORD_W-1:0]   pend_w [NWORDS];
    logic [WORD_W-1:0]   isr_w  [NWORDS];
    logic [WORD_W-1:0]   tmr_w  [NWORDS];

    // Filter out the reserved low vectors.
    assign req_ok = req_valid && (req_vec >= VW'(MIN_VEC));

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_bit
        localparam logic [VW-1:0] VV = VW'(v);
        // Per-vector update: request sets pending, take moves to service, EOI retires.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pend[v] <= 1'b0;
                isr[v]  <= 1'b0;
                tmr[v]  <= 1'b0;
                byp[v]  <= 1'b0;
            end else begin
                if (req_ok && req_vec == VV) begin
                    pend[v] <= 1'b1;
                    tmr[v]  <= req_level;
                    byp[v]  <= req_bypass;
                end else if (take && take_vec == VV) begin
                    pend[v] <= 1'b0;
                end
                if (take && take_vec == VV) begin
                    isr[v] <= 1'b1;
                end else if (eoi_do && eoi_vec == VV) begin
                    isr[v] <= 1'b0;
                end
            end
        end
    end

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        assign pend_w[w] = pend[w*WORD_W +: WORD_W];
        assign isr_w[w]  = isr[w*WORD_W +: WORD_W];
        assign tmr_w[w]  = tmr[w*WORD_W +: WORD_W];
    end

    // Readout multiplexer over bank and word.
    always_comb begin
        case (rd_bank)
            BANK_PEND: rd_data = pend_w[rd_word];
            BANK_ISR:  rd_data = isr_w[rd_word];
            BANK_TRIG: rd_data = tmr_w[rd_word];
            default:   rd_data = '0;
        endcase
    end

    AST_REQ_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        req_ok |=> pend[$past(req_vec)]); // R2
    AST_EOI_DROPS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_do && !take) |=> ($countones(isr) == $countones($past(isr)) - 1)); // R8
endmodule

// File: rtl/lpic_ctrl.sv
// Local interrupt priority controller top level.
// Derives the processor priority, picks the winning eligible vector, answers
// acknowledge cycles and retires in-service vectors on end-of-interrupt.
// Assumes the class is the top four bits of the vector and that the caller
// issues at most one of request, acknowledge and EOI in a given cycle.
module lpic_ctrl #(
    parameter int              NUM_VEC  = 256,
    parameter int              WORD_W   = 32,
    parameter int              MIN_VEC  = 16,
    parameter logic [7:0]      SPUR_RST = 8'hFF,
    localparam int             VW       = $clog2(NUM_VEC),
    localparam int             NWORDS   = NUM_VEC / WORD_W,
    localparam int             WSW      = $clog2(NWORDS),
    localparam int             CW       = lpic_pkg::CLASS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [VW-1:0]     req_vector,
    input  logic              req_level,
    input  logic              req_bypass,
    input  logic              tpr_we,
    input  logic [VW-1:0]     tpr_wdata,
    input  logic              svr_we,
    input  logic [VW:0]       svr_wdata,
    input  logic              eoi_we,
    input  logic              inta,
    input  logic [1:0]        rd_bank,
    input  logic [WSW-1:0]    rd_word,
    output logic              irq_out,
    output logic              ack_valid,
    output logic [VW-1:0]     ack_vector,
    output logic              ack_spurious,
    output logic [VW-1:0]     ppr_out,
    output logic              eoi_bcast,
    output logic [VW-1:0]     eoi_bcast_vector,
    output logic [WORD_W-1:0] rd_data
);
    import lpic_pkg::*;

    logic [VW-1:0]      tpr_q;
    logic [VW-1:0]      svr_vec_q;
    logic               svr_en_q;
    logic [NUM_VEC-1:0] pend, isr, tmr, byp, elig;
    logic               isr_found, win_found, take, eoi_do;
    logic [VW-1:0]      isr_idx, win_idx;
    logic [CW-1:0]      tpr_cls, isr_cls, ppr_cls;

    lpic_vec_store #(
        .NUM_VEC (NUM_VEC),
        .WORD_W  (WORD_W),
        .MIN_VEC (MIN_VEC)
    ) store_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_vec    (req_vector),
        .req_level  (req_level),
        .req_bypass (req_bypass),
        .take       (take),
        .take_vec   (win_idx),
        .eoi_do     (eoi_do),
        .eoi_vec    (isr_idx),
        .rd_bank    (bank_e'(rd_bank)),
        .rd_word    (rd_word),
        .pend       (pend),
        .isr        (isr),
        .tmr        (tmr),
        .byp        (byp),
        .rd_data    (rd_data)
    );

    lpic_find_top #(.N(NUM_VEC)) isr_top_i (
        .bits  (isr),
        .found (isr_found),
        .idx   (isr_idx)
    );

    // Processor priority: the larger of task class and top in-service class.
    always_comb begin
        tpr_cls = tpr_q[VW-1 -: CW];
        isr_cls = isr_found ? isr_idx[VW-1 -: CW] : '0;
        if (tpr_cls >= isr_cls) begin
            ppr_cls = tpr_cls;
            ppr_out = tpr_q;
        end else begin
            ppr_cls = isr_cls;
            ppr_out = {isr_cls, {(VW-CW){1'b0}}};
        end
    end

    for (genvar v = 0; v < NUM_VEC; v++) begin : g_elig
        localparam logic [CW-1:0] VCLS = CW'(v >> (VW - CW));
        assign elig[v] = pend[v] && (byp[v] || (VCLS > ppr_cls));
    end

    lpic_find_top #(.N(NUM_VEC)) win_i (
        .bits  (elig),
        .found (win_found),
        .idx   (win_idx)
    );

    assign irq_out = svr_en_q && win_found;
    assign take    = inta && irq_out;
    assign eoi_do  = eoi_we && isr_found;

    // Software-written task priority and spurious register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tpr_q     <= '0;
            svr_vec_q <= VW'(SPUR_RST);
            svr_en_q  <= 1'b0;
        end else begin
            if (tpr_we) tpr_q <= tpr_wdata;
            if (svr_we) begin
                svr_vec_q <= svr_wdata[VW-1:0];
                svr_en_q  <= svr_wdata[VW];
            end
        end
    end

    // Acknowledge answer, valid one cycle after inta.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_valid    <= 1'b0;
            ack_vector   <= '0;
            ack_spurious <= 1'b0;
        end else begin
            ack_valid <= inta;
            if (inta) begin
                ack_vector   <= take ? win_idx : svr_vec_q;
                ack_spurious <= !take;
            end
        end
    end

    // Broadcast pulse for retired level-triggered vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eoi_bcast        <= 1'b0;
            eoi_bcast_vector <= '0;
        end else begin
            eoi_bcast <= eoi_do && tmr[isr_idx];
            if (eoi_do) eoi_bcast_vector <= isr_idx;
        end
    end

    AST_SPUR_KEEPS_ISR: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && !take && !eoi_we) |=> $stable(isr)); // R6
    AST_ACK_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_spurious) |-> isr[ack_vector]); // R5
    AST_BCAST_AFTER_EOI: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bcast |-> $past(eoi_we)); // R9
    AST_ACK_FOLLOWS_INTA: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(inta)); // R5
endmodule

// File: tb/lpic_ctrl_tb_top.sv
`timescale 1ns/1ps
module lpic_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_level, req_bypass, tpr_we, svr_we, eoi_we, inta;
    logic [7:0]  req_vector, tpr_wdata;
    logic [8:0]  svr_wdata;
    logic [1:0]  rd_bank;
    logic [2:0]  rd_word;
    logic        irq_out, ack_valid, ack_spurious, eoi_bcast;
    logic [7:0]  ack_vector, ppr_out, eoi_bcast_vector;
    logic [31:0] rd_data;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference state built from the requirements.
    logic [255:0] m_pend, m_isr, m_tmr, m_byp;
    logic [7:0]   m_tpr, m_svr;
    logic         m_en;
    logic         e_ack_valid, e_spur, e_bcast;
    logic [7:0]   e_ack_vec, e_bcast_vec;

    always #2.5 clk = ~clk;

    lpic_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vector(req_vector),
        .req_level(req_level), .req_bypass(req_bypass), .tpr_we(tpr_we),
        .tpr_wdata(tpr_wdata), .svr_we(svr_we), .svr_wdata(svr_wdata),
        .eoi_we(eoi_we), .inta(inta), .rd_bank(rd_bank), .rd_word(rd_word),
        .irq_out(irq_out), .ack_valid(ack_valid), .ack_vector(ack_vector),
        .ack_spurious(ack_spurious), .ppr_out(ppr_out), .eoi_bcast(eoi_bcast),
        .eoi_bcast_vector(eoi_bcast_vector), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int m_isr_top();
        for (int v = 255; v >= 0; v--) if (m_isr[v]) return v;
        return -1;
    endfunction

    function automatic logic [7:0] m_ppr();
        int t = m_isr_top();
        logic [3:0] ic = (t >= 0) ? t[7:4] : 4'd0;
        return (m_tpr[7:4] >= ic) ? m_tpr : {ic, 4'd0};
    endfunction

    function automatic int m_win();
        logic [3:0] pc = m_ppr() >> 4;
        for (int v = 255; v >= 0; v--) begin
            logic [7:0] vv = 8'(v);
            if (m_pend[v] && (m_byp[v] || vv[7:4] > pc)) return v;
        end
        return -1;
    endfunction

    task automatic idle();
        req_valid = 0; req_vector = 0; req_level = 0; req_bypass = 0;
        tpr_we = 0; tpr_wdata = 0; svr_we = 0; svr_wdata = 0; eoi_we = 0; inta = 0;
    endtask

    // Apply the driven op to the model, clock once, then compare at the low phase.
    task automatic step();
        int w, t;
        e_ack_valid = inta;
        e_bcast = 1'b0;
        if (req_valid && req_vector >= 8'd16) begin
            m_pend[req_vector] = 1'b1;
            m_tmr[req_vector] = req_level;
            m_byp[req_vector] = req_bypass;
        end
        if (inta) begin
            w = m_en ? m_win() : -1;
            if (w >= 0) begin
                m_pend[w] = 1'b0; m_isr[w] = 1'b1;
                e_ack_vec = 8'(w); e_spur = 1'b0;
            end else begin
                e_ack_vec = m_svr; e_spur = 1'b1;
            end
        end
        if (eoi_we) begin
            t = m_isr_top();
            if (t >= 0) begin
                e_bcast = m_tmr[t];
                if (m_tmr[t]) e_bcast_vec = 8'(t);
                m_isr[t] = 1'b0;
            end
        end
        if (tpr_we) m_tpr = tpr_wdata;
        if (svr_we) begin m_svr = svr_wdata[7:0]; m_en = svr_wdata[8]; end
        @(posedge clk);
        @(negedge clk);
        idle();
        check_all();
    endtask

    task automatic check_all();
        logic [2:0] w = 3'($urandom_range(0, 7));
        logic exp_irq = m_en && (m_win() >= 0);
        chk(irq_out === exp_irq, "R4 irq_out", 32'(irq_out), 32'(exp_irq));
        chk(ppr_out === m_ppr(), "R3 ppr_out", 32'(ppr_out), 32'(m_ppr()));
        chk(ack_valid === e_ack_valid, "R5 ack_valid", 32'(ack_valid), 32'(e_ack_valid));
        if (e_ack_valid) begin
            chk(ack_vector === e_ack_vec, e_spur ? "R6 spurious vector" : "R5 ack_vector",
                32'(ack_vector), 32'(e_ack_vec));
            chk(ack_spurious === e_spur, "R6 ack_spurious", 32'(ack_spurious), 32'(e_spur));
        end
        chk(eoi_bcast === e_bcast, "R9 eoi_bcast", 32'(eoi_bcast), 32'(e_bcast));
        if (e_bcast)
            chk(eoi_bcast_vector === e_bcast_vec, "R9 bcast vector", 32'(eoi_bcast_vector), 32'(e_bcast_vec));
        rd_word = w;
        rd_bank = 2'd0; #0.2;
        chk(rd_data === m_pend[w*32 +: 32], "R2 pending word", rd_data, m_pend[w*32 +: 32]);
        rd_bank = 2'd1; #0.2;
        chk(rd_data === m_isr[w*32 +: 32], "R8 in-service word", rd_data, m_isr[w*32 +: 32]);
        rd_bank = 2'd2; #0.2;
        chk(rd_data === m_tmr[w*32 +: 32], "R11 trigger word", rd_data, m_tmr[w*32 +: 32]);
        rd_bank = 2'd3; #0.2;
        chk(rd_data === 32'd0, "R11 empty bank", rd_data, 32'd0);
    endtask

    task automatic do_req(input logic [7:0] v, input logic lvl, input logic bp);
        req_valid = 1; req_vector = v; req_level = lvl; req_bypass = bp; step();
    endtask
    task automatic do_tpr(input logic [7:0] t); tpr_we = 1; tpr_wdata = t; step(); endtask
    task automatic do_svr(input logic [8:0] s); svr_we = 1; svr_wdata = s; step(); endtask
    task automatic do_ack(); inta = 1; step(); endtask
    task automatic do_eoi(); eoi_we = 1; step(); endtask

    initial begin
        #400000;
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed1));
        idle(); rd_bank = 0; rd_word = 0;
        rst_n = 0;
        m_pend = '0; m_isr = '0; m_tmr = '0; m_byp = '0;
        m_tpr = 0; m_svr = 8'hFF; m_en = 0;
        e_ack_valid = 0; e_spur = 0; e_bcast = 0; e_ack_vec = 0; e_bcast_vec = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check_all(); // R1 reset state
        // R1: spurious register resets to 0xFF, disabled
        do_ack();
        // R10: disabled controller keeps line low and answers spurious
        do_req(8'h70, 0, 0);
        chk(irq_out === 1'b0, "R10 irq while disabled", 32'(irq_out), 0);
        do_ack();
        do_svr({1'b1, 8'h1F});
        do_ack(); // takes 0x70
        do_eoi();
        // R2: low vector ignored
        do_req(8'h05, 0, 0);
        do_req(8'h0F, 1, 0);
        // R3/R4: equal class does not interrupt
        do_req(8'h41, 0, 0);
        do_tpr(8'h40);
        chk(irq_out === 1'b0, "R4 equal class blocked", 32'(irq_out), 0);
        // R6: masked after request gives spurious
        do_ack();
        do_tpr(8'h30);
        do_ack(); // R5 takes 0x41, ppr becomes 0x40
        // R7: bypass under class 15
        do_tpr(8'hF0);
        do_req(8'h22, 0, 1);
        chk(irq_out === 1'b1, "R7 bypass delivered", 32'(irq_out), 1);
        do_ack();
        do_tpr(8'h00);
        // R9: level vector retirement broadcasts
        do_req(8'h90, 1, 0);
        do_ack();
        do_eoi();
        do_eoi();
        do_eoi();
        do_eoi(); // R8: empty in-service, no effect
        // Random phase
        for (int i = 0; i < 4000; i++) begin
            int op = $urandom_range(0, 99);
            if (op < 40) do_req(8'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
                                ($urandom_range(0, 9) == 0));
            else if (op < 65) do_ack();
            else if (op < 85) do_eoi();
            else if (op < 97) do_tpr(8'($urandom_range(0, 255)) & 8'hBF);
            else do_svr({($urandom_range(0, 4) != 0), 8'($urandom_range(0, 255))});
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule